// File: doc/BRIEF.md
# Maskable Event Interrupt Controller

This block gathers single-cycle event pulses from two sources into sticky notification bits and drives one active-low interrupt line toward a host. The communication group holds four events: a packet arrived, a remote write finished, a remote read finished, and a restart happened. The protection group holds six events: thermistor 1, thermistor 2, over-voltage, short-circuit, maximum-duty and over-current.

A notification bit always records its event. The interrupt line is pulled low only by an event that is enabled. The communication group has one enable that covers all four of its events. The protection group has one enable per event and a master enable above them. The line stays low until the host writes the reset bit of the group that raised it. A reset write also clears that group's notification bits. An event that arrives in the same cycle as the reset write wins over it, so the line stays low.

The host reaches the block through a simple register port. Writes are single-cycle strobes and reads are combinational. Supply under-voltage is not one of the inputs and raises no event.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Any event pulse sets its notification bit on the next clock edge, whatever the enable settings. Communication status is read at address 0, with bit 0 for packet, bit 1 for write done, bit 2 for read done and bit 3 for restart. Protection status is read at address 2, with bit 0 for thermistor 1, bit 1 for thermistor 2, bit 2 for over-voltage, bit 3 for short-circuit, bit 4 for maximum duty and bit 5 for over-current.
- R2: An event that is enabled drives irq_n to 0 at the clock edge that samples it. Writing the owning group's reset bit returns irq_n to 1 at the next edge, provided no other pending condition remains.
- R3: Once irq_n is low, it stays low until the reset bit is written. Clearing the enable after the event does not release it.
- R4: When a group reset write and an event of that group fall in the same cycle, the event's notification bit stays set. If that event is enabled, irq_n stays low.
- R5: The communication enable is bit 0 at address 1 and covers all four communication events. The communication reset is bit 1 at address 1. It clears all four communication notification bits and the pending communication interrupt.
- R6: The protection per-event enables are bits 5:0 at address 3, with the same bit order as the status register. A protection event whose enable is 0 sets its notification bit but does not move irq_n.
- R7: The protection master enable is bit 0 at address 4. While it is 0, no protection event drives irq_n low, whatever the per-event enables hold.
- R8: The protection reset is bit 1 at address 4. A group reset write clears only the notification bits and pending interrupt of its own group. The other group is untouched.
- R9: The reset bits are not stored and always read as 0. Enable bits read back as written. Addresses 5 to 7 and unused bit positions read as 0.
- R10: irq_n comes from a flip-flop, so it does not change before the clock edge that samples an event. A synchronous reset sets irq_n to 1 and clears all notification and enable bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| comm_evt | input | 4 | Communication event pulses |
| prot_evt | input | 6 | Protection event pulses |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt, registered |

## Verification
Assertions check on every cycle that an event pulse sets its notification bit, that a reset write with no coincident event clears it, and that a pending interrupt survives every cycle without a reset write. They also check that irq_n always equals the inverse of the two pending latches, and that with the master enable off the protection latch cannot rise. The bench scenarios show how the pieces combine at the ports. This covers enables changed after an event, a reset write colliding with an event, one group's reset leaving the other group alone, the register read-back values, and the exact edge at which irq_n moves.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

    parameter int COMM_N = 4;
    parameter int PROT_N = 6;
    parameter int ADDR_W = 3;
    parameter int DATA_W = 8;

    localparam logic [ADDR_W-1:0] A_COMM_STAT = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_COMM_CTRL = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_PROT_STAT = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_PROT_IE   = ADDR_W'(3);
    localparam logic [ADDR_W-1:0] A_PROT_CTRL = ADDR_W'(4);

    localparam int EN_BIT  = 0;
    localparam int CLR_BIT = 1;

    typedef struct packed {
        logic              comm_en;
        logic              prot_master;
        logic [PROT_N-1:0] prot_ie;
    } irq_ctrl_t;

    function automatic logic hit(input logic we, input logic [ADDR_W-1:0] a,
                                 input logic [ADDR_W-1:0] target);
        return we && (a == target);
    endfunction

endpackage

// File: rtl/evt_irq_group.sv
module evt_irq_group
    import evt_irq_pkg::*;
#(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] evt,
    input  logic [N-1:0] mask,
    input  logic         clr,
    output logic [N-1:0] notif,
    output logic         pend,
    output logic         pend_nxt
);

    logic hit_any;
    assign hit_any  = |(evt & mask);
    assign pend_nxt = (pend && !clr) || hit_any;

    always_ff @(posedge clk) begin
        if (rst) pend <= 1'b0;
        else     pend <= pend_nxt;
    end

    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)         notif[i] <= 1'b0;
            else if (evt[i]) notif[i] <= 1'b1;
            else if (clr)    notif[i] <= 1'b0;
        end

        // R1
        evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
            evt[i] |=> notif[i]);

        // R5
        clr_clears_chk: assert property (@(posedge clk) disable iff (rst)
            (clr && !evt[i]) |=> !notif[i]);
    end

    // R3
    pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

    // R6
    no_spurious_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend && !(|(evt & mask))) |=> !pend);

endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [COMM_N-1:0] comm_notif,
    input  logic [PROT_N-1:0] prot_notif,
    output irq_ctrl_t         ctrl,
    output logic              comm_clr,
    output logic              prot_clr,
    output logic [DATA_W-1:0] rd_data
);

    logic unused_data;
    assign unused_data = ^wr_data;

    logic comm_wr, ie_wr, prot_wr;
    assign comm_wr = hit(wr_en, wr_addr, A_COMM_CTRL);
    assign ie_wr   = hit(wr_en, wr_addr, A_PROT_IE);
    assign prot_wr = hit(wr_en, wr_addr, A_PROT_CTRL);

    assign comm_clr = comm_wr && wr_data[CLR_BIT];
    assign prot_clr = prot_wr && wr_data[CLR_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else begin
            if (comm_wr) ctrl.comm_en     <= wr_data[EN_BIT];
            if (prot_wr) ctrl.prot_master <= wr_data[EN_BIT];
            if (ie_wr)   ctrl.prot_ie     <= wr_data[PROT_N-1:0];
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            A_COMM_STAT: rd_data = DATA_W'(comm_notif);
            A_COMM_CTRL: rd_data[EN_BIT] = ctrl.comm_en;
            A_PROT_STAT: rd_data = DATA_W'(prot_notif);
            A_PROT_IE:   rd_data = DATA_W'(ctrl.prot_ie);
            A_PROT_CTRL: rd_data[EN_BIT] = ctrl.prot_master;
            default:     rd_data = '0;
        endcase
    end

    // R9
    comm_en_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !comm_wr |=> $stable(ctrl.comm_en));

    // R9
    prot_ie_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !ie_wr |=> $stable(ctrl.prot_ie));

endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [COMM_N-1:0] comm_evt,
    input  logic [PROT_N-1:0] prot_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_n
);

    irq_ctrl_t         ctrl;
    logic              comm_clr, prot_clr;
    logic [COMM_N-1:0] comm_notif;
    logic [PROT_N-1:0] prot_notif;
    logic              comm_pend, comm_pend_nxt;
    logic              prot_pend, prot_pend_nxt;
    logic [COMM_N-1:0] comm_mask;
    logic [PROT_N-1:0] prot_mask;

    assign comm_mask = {COMM_N{ctrl.comm_en}};
    assign prot_mask = ctrl.prot_ie & {PROT_N{ctrl.prot_master}};

    evt_irq_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .comm_notif (comm_notif),
        .prot_notif (prot_notif),
        .ctrl       (ctrl),
        .comm_clr   (comm_clr),
        .prot_clr   (prot_clr),
        .rd_data    (rd_data)
    );

    evt_irq_group #(.N(COMM_N)) u_comm (
        .clk      (clk),
        .rst      (rst),
        .evt      (comm_evt),
        .mask     (comm_mask),
        .clr      (comm_clr),
        .notif    (comm_notif),
        .pend     (comm_pend),
        .pend_nxt (comm_pend_nxt)
    );

    evt_irq_group #(.N(PROT_N)) u_prot (
        .clk      (clk),
        .rst      (rst),
        .evt      (prot_evt),
        .mask     (prot_mask),
        .clr      (prot_clr),
        .notif    (prot_notif),
        .pend     (prot_pend),
        .pend_nxt (prot_pend_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_n <= 1'b1;
        else     irq_n <= !(comm_pend_nxt || prot_pend_nxt);
    end

    // R10
    irq_tracks_pend_chk: assert property (@(posedge clk) disable iff (rst)
        irq_n == !(comm_pend || prot_pend));

    // R7
    master_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.prot_master && !prot_pend) |=> !prot_pend);

endmodule

// File: tb/evt_irq_ctrl_tb_top.sv
module evt_irq_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] comm_evt;
    logic [5:0] prot_evt;
    logic       wr_en;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;
    logic [2:0] rd_addr;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    evt_irq_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .comm_evt (comm_evt),
        .prot_evt (prot_evt),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .irq_n    (irq_n)
    );

    // row: wr, addr, data, comm_evt, prot_evt | exp irq_n, exp comm stat, exp prot stat
    localparam int NV = 20;
    localparam logic [32:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 4'h1, 6'h00, 1'b1, 4'h1, 6'h00}, // R1 disabled comm event latches
        {1'b1, 3'd1, 8'h01, 4'h0, 6'h00, 1'b1, 4'h1, 6'h00}, // R5 enable comm
        {1'b0, 3'd0, 8'h00, 4'h4, 6'h00, 1'b0, 4'h5, 6'h00}, // R2 enabled event drops irq
        {1'b1, 3'd1, 8'h00, 4'h0, 6'h00, 1'b0, 4'h5, 6'h00}, // R3 disable keeps irq low
        {1'b1, 3'd1, 8'h02, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00}, // R5 reset clears all
        {1'b1, 3'd1, 8'h01, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00},
        {1'b1, 3'd1, 8'h03, 4'h8, 6'h00, 1'b0, 4'h8, 6'h00}, // R4 event beats reset
        {1'b1, 3'd1, 8'h03, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00}, // R2 reset releases
        {1'b0, 3'd0, 8'h00, 4'h0, 6'h01, 1'b1, 4'h0, 6'h01}, // R6 disabled prot event
        {1'b1, 3'd3, 8'h3F, 4'h0, 6'h00, 1'b1, 4'h0, 6'h01},
        {1'b0, 3'd0, 8'h00, 4'h0, 6'h04, 1'b1, 4'h0, 6'h05}, // R7 master off
        {1'b1, 3'd4, 8'h01, 4'h0, 6'h00, 1'b1, 4'h0, 6'h05},
        {1'b0, 3'd0, 8'h00, 4'h0, 6'h20, 1'b0, 4'h0, 6'h25}, // R7 master on
        {1'b1, 3'd1, 8'h03, 4'h0, 6'h00, 1'b0, 4'h0, 6'h25}, // R8 comm reset leaves prot
        {1'b1, 3'd4, 8'h03, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00}, // R8 prot reset
        {1'b1, 3'd3, 8'h10, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00},
        {1'b0, 3'd0, 8'h00, 4'h0, 6'h08, 1'b1, 4'h0, 6'h08}, // R6 short masked
        {1'b0, 3'd0, 8'h00, 4'h0, 6'h10, 1'b0, 4'h0, 6'h18}, // R6 max duty enabled
        {1'b1, 3'd4, 8'h03, 4'h0, 6'h10, 1'b0, 4'h0, 6'h10}, // R4 prot event beats reset
        {1'b1, 3'd4, 8'h03, 4'h0, 6'h00, 1'b1, 4'h0, 6'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        comm_evt = '0; prot_evt = '0;
    endtask

    task automatic step(input logic w, input logic [2:0] a, input logic [7:0] d,
                        input logic [3:0] ce, input logic [5:0] pe);
        @(negedge clk);
        wr_en = w; wr_addr = a; wr_data = d; comm_evt = ce; prot_evt = pe;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        idle_inputs();
        rd_addr = '0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R10 reset state
        chk("R10 reset irq_n", {7'd0, irq_n}, 8'h01);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R10 reset register", v, 8'h00);
        end

        for (int i = 0; i < NV; i++) begin
            logic [32:0] r;
            r = VEC[i];
            step(r[32], r[31:29], r[28:21], r[20:17], r[16:11]);
            chk("table irq_n", {7'd0, irq_n}, {7'd0, r[10]});
            rd(3'd0, v);
            chk("table comm status R1", v, {4'd0, r[9:6]});
            rd(3'd2, v);
            chk("table prot status R1", v, {2'd0, r[5:0]});
        end

        // R9 read-back: comm en 1, prot ie 0x10, master 1, reset bits read 0
        rd(3'd1, v); chk("R9 comm ctrl readback", v, 8'h01);
        rd(3'd3, v); chk("R9 prot enable readback", v, 8'h10);
        rd(3'd4, v); chk("R9 prot ctrl readback", v, 8'h01);
        rd(3'd5, v); chk("R9 unused address", v, 8'h00);
        rd(3'd7, v); chk("R9 unused address", v, 8'h00);

        // R10 irq_n moves only at the sampling edge
        @(negedge clk);
        comm_evt = 4'h2;
        #1;
        chk("R10 irq before edge", {7'd0, irq_n}, 8'h01);
        @(posedge clk);
        #1;
        idle_inputs();
        chk("R10 irq after edge", {7'd0, irq_n}, 8'h00);

        // R8 prot reset must not release a comm interrupt
        step(1'b1, 3'd4, 8'h03, 4'h0, 6'h00);
        chk("R8 prot reset keeps comm irq", {7'd0, irq_n}, 8'h00);
        rd(3'd0, v); chk("R8 comm status kept", v, 8'h02);

        // R2 release by comm reset
        step(1'b1, 3'd1, 8'h03, 4'h0, 6'h00);
        chk("R2 release", {7'd0, irq_n}, 8'h01);

        // R10 reset mid-run clears state
        step(1'b0, 3'd0, 8'h00, 4'h1, 6'h3F);
        chk("R10 pre-reset irq", {7'd0, irq_n}, 8'h00);
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        chk("R10 post-reset irq", {7'd0, irq_n}, 8'h01);
        rd(3'd0, v); chk("R10 post-reset comm status", v, 8'h00);
        rd(3'd2, v); chk("R10 post-reset prot status", v, 8'h00);
        rd(3'd3, v); chk("R10 post-reset prot enables", v, 8'h00);

        finish_run();
    end

endmodule